// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block is a parallel-in, serial-out shift register that runs entirely on a fast system clock. A slower external shift clock and a second, interchangeable clock input are sampled by the block. While an active-low load control is held low, the register follows the parallel data word on every cycle. While the load control is high, each effective rising edge of the combined shift clock moves the stored word one place toward the serial output. The last stage drives a true serial output and its complement.

The two clock inputs are combined with an OR. Either input can therefore act as the shift clock, and holding either one high inhibits clocking through the other. Both inputs pass through a two-flop synchronizer before edge detection. Analogue setup and hold windows are replaced by plain synchronous sampling of the load control, the parallel word and the serial input.

Top module: `piso_shreg`

## Requirements
- R1: The register has W stages (default 8). Stage order runs from parallel bit 0 (first stage) to bit W-1 (last stage), and `ser_o` shows the last stage. After W shifts, the serial output shows the first bit that was shifted in.
- R2: While `load_ni` is low, every stage takes the matching `par_i` bit at each system clock edge, and changes on `par_i` keep being followed. The load takes priority over any clock edge.
- R3: When `load_ni` is high and an effective rising clock edge is detected, every stage takes the value of the stage before it, and the first stage takes `ser_i`.
- R4: The effective clock is the OR of `sclk_a_i` and `sclk_b_i`. Either input works as the clock, and while one is held high, edges on the other cause no shift.
- R5: A rising edge on either input while the other is low causes exactly one shift. Raising one input while the other is already high causes no shift.
- R6: An effective edge that occurs while `load_ni` is low is discarded. Releasing `load_ni` with the combined clock already high causes no shift.
- R7: `ser_no` is always the inverse of `ser_o`.
- R8: While `rst_ni` is low at a clock edge, all stages, the synchronizers and the edge history are cleared. After that edge, `ser_o` is 0 and `ser_no` is 1.
- R9: A change of a clock input that is driven between system edges takes effect at the third rising system clock edge after it: two synchronizer stages, then the shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| sclk_a_i | input | 1 | Shift clock input A (asynchronous) |
| sclk_b_i | input | 1 | Shift clock input B / inhibit (asynchronous) |
| load_ni | input | 1 | Active-low parallel load control |
| par_i | input | W | Parallel data, bit 0 enters the first stage |
| ser_i | input | 1 | Serial data into the first stage |
| ser_o | output | 1 | Last stage |
| ser_no | output | 1 | Inverse of the last stage |

## Verification
The bench checks that one clock input raised while the other is high causes no shift. A design that edge-detects each input on its own would shift on that edge. It also raises the clock during a load and then releases the load with the clock still high. A detector that does not update its history during a load would produce a stray shift there. The parallel word is changed in the middle of a load, which catches a load latched only on its falling edge. The exact cycle of the first shift is sampled, which exposes a synchronizer that is one stage too short or too long.

// File: rtl/piso_pkg.sv
// Package: default sizes shared by the shift register and its checker.
package piso_pkg;
    parameter int unsigned PISO_WIDTH  = 8;
    parameter int unsigned SYNC_DEPTH  = 2;
    parameter int unsigned CLK_INPUTS  = 2;
endpackage

// File: rtl/piso_sync.sv
// Multi-bit flop synchronizer.
// Assumes: each bit is an independent level. No bus coherence is implied.
module piso_sync #(
    parameter int unsigned W     = 2,
    parameter int unsigned DEPTH = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [DEPTH];

    // First flop samples the asynchronous inputs.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) stage_q[0] <= '0;
        else         stage_q[0] <= d_i;
    end

    for (genvar k = 1; k < DEPTH; k++) begin : g_stage
        // Each later flop retimes the previous one.
        always_ff @(posedge clk_i) begin
            if (!rst_ni) stage_q[k] <= '0;
            else         stage_q[k] <= stage_q[k-1];
        end
    end

    assign q_o = stage_q[DEPTH-1];
endmodule

// File: rtl/piso_edge.sv
// Combines synchronized clock inputs with an OR and flags its rising edge.
// Assumes: inputs are already in the system clock domain.
module piso_edge #(
    parameter int unsigned N = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] clks_i,
    output logic         rise_o
);
    logic comb_clk;
    logic prev_q;

    assign comb_clk = |clks_i;

    // History of the combined clock; updates regardless of load state.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) prev_q <= 1'b0;
        else         prev_q <= comb_clk;
    end

    assign rise_o = comb_clk & ~prev_q;
endmodule

// File: rtl/piso_chain.sv
// Storage stages with a level-sensitive parallel load that wins over shifting.
// Assumes: shift_i is a single-cycle pulse per effective clock edge.
module piso_chain #(
    parameter int unsigned W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_ni,
    input  logic         shift_i,
    input  logic [W-1:0] par_i,
    input  logic         ser_i,
    output logic [W-1:0] stage_o
);
    logic [W-1:0] stage_q;

    // Load follows par_i each cycle; otherwise shift toward the top bit.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)       stage_q <= '0;
        else if (!load_ni) stage_q <= par_i;
        else if (shift_i)  stage_q <= {stage_q[W-2:0], ser_i};
    end

    assign stage_o = stage_q;
endmodule

// File: rtl/piso_shreg.sv
// Top: parallel-load serial-out shift register on a system clock.
// Assumes: sclk_a_i/sclk_b_i are asynchronous and slow against clk_i, and
// load_ni, par_i and ser_i are synchronous to clk_i.
module piso_shreg #(
    parameter int unsigned W = piso_pkg::PISO_WIDTH
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         sclk_a_i,
    input  logic         sclk_b_i,
    input  logic         load_ni,
    input  logic [W-1:0] par_i,
    input  logic         ser_i,
    output logic         ser_o,
    output logic         ser_no
);
    localparam int unsigned NCLK = piso_pkg::CLK_INPUTS;

    logic [NCLK-1:0] clk_sync;
    logic            shift_fire;
    logic [W-1:0]    stage_q;

    piso_sync #(.W(NCLK), .DEPTH(piso_pkg::SYNC_DEPTH)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    ({sclk_b_i, sclk_a_i}),
        .q_o    (clk_sync)
    );

    piso_edge #(.N(NCLK)) u_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clks_i (clk_sync),
        .rise_o (shift_fire)
    );

    piso_chain #(.W(W)) u_chain (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_ni (load_ni),
        .shift_i (shift_fire),
        .par_i   (par_i),
        .ser_i   (ser_i),
        .stage_o (stage_q)
    );

    assign ser_o  = stage_q[W-1];
    assign ser_no = ~stage_q[W-1];
endmodule

// File: rtl/piso_shreg_chk.sv
// Checker for piso_shreg, bound to every instance.
module piso_shreg_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk_i,
    input logic         rst_ni,
    input logic         load_ni,
    input logic [W-1:0] par_i,
    input logic         ser_i,
    input logic         fire_i,
    input logic [W-1:0] stage_i
);
    // R2
    load_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !load_ni |=> stage_i == $past(par_i));
    // R3
    shift_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (load_ni && fire_i) |=> stage_i == {$past(stage_i[W-2:0]), $past(ser_i)});
    // R6
    hold_no_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (load_ni && !fire_i) |=> $stable(stage_i));
    // R5
    single_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fire_i |=> !fire_i);
    // R8
    reset_clear_chk: assert property (@(posedge clk_i)
        !rst_ni |=> stage_i == '0);
endmodule

bind piso_shreg piso_shreg_chk #(.W(W)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_ni (load_ni),
    .par_i   (par_i),
    .ser_i   (ser_i),
    .fire_i  (shift_fire),
    .stage_i (stage_q)
);

// File: tb/sim_piso_shreg.sv
`timescale 1ns/1ps
module sim_piso_shreg;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sa = 1'b0, sb = 1'b0, load_n = 1'b1, sin = 1'b0;
    logic [W-1:0] par = '0;
    logic         so, sno;

    int    n_chk = 0, n_bad = 0;
    string cur_req = "R8";
    bit    live = 1'b0;

    always #4 clk = ~clk;

    piso_shreg #(.W(W)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .sclk_a_i(sa), .sclk_b_i(sb),
        .load_ni(load_n), .par_i(par), .ser_i(sin), .ser_o(so), .ser_no(sno)
    );

    // Behavioural reference: queue of raw clock ORs and a bit queue of stages.
    bit mq[$]   = '{0, 0};
    bit mprev   = 0;
    bit mreg[$] = '{0, 0, 0, 0, 0, 0, 0, 0};

    always @(posedge clk) begin
        bit cur;
        if (!rst_n) begin
            mq = '{0, 0}; mprev = 0;
            mreg = '{0, 0, 0, 0, 0, 0, 0, 0};
        end else begin
            cur = mq[0];
            if (!load_n) begin
                for (int i = 0; i < W; i++) mreg[i] = par[i];
            end else if (cur && !mprev) begin
                mreg.push_front(sin);
                void'(mreg.pop_back());
            end
            mprev = cur;
            void'(mq.pop_front());
            mq.push_back(sa | sb);
        end
    end

    task automatic chk(input logic act, input logic exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Cycle compare against the model, away from the active edge (R7 also).
    always @(negedge clk) begin
        if (live) begin
            chk(so, mreg[W-1], cur_req);
            chk(sno, ~mreg[W-1], "R7");
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load_word(input logic [W-1:0] w);
        load_n = 1'b0; par = w; tick(1);
        load_n = 1'b1; tick(1);
    endtask

    task automatic pulse_a();
        sa = 1'b1; tick(4); sa = 1'b0; tick(4);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #(200000 * 8);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [W-1:0] pat;
        tick(3);
        // R8: reset state
        chk(so, 1'b0, "R8"); chk(sno, 1'b1, "R8");
        rst_n = 1'b1; tick(1); live = 1'b1;

        // R2: level load follows par while low
        cur_req = "R2";
        load_n = 1'b0; par = 8'h80; tick(1);
        chk(so, 1'b1, "R2");
        par = 8'h00; tick(1);
        chk(so, 1'b0, "R2");
        load_n = 1'b1; tick(1);

        // R1/R3/R9: shift out a word, ser_i fills from the first stage
        cur_req = "R3";
        pat = 8'hB4; sin = 1'b1;
        load_word(pat);
        sa = 1'b1; tick(2);
        chk(so, pat[7], "R9");
        tick(1);
        chk(so, pat[6], "R9");
        tick(1); sa = 1'b0; tick(4);
        for (int k = 2; k < W; k++) begin
            pulse_a();
            chk(so, pat[W-1-k], "R3");
        end
        pulse_a();
        chk(so, 1'b1, "R1");

        // R4/R5: one input as inhibit
        cur_req = "R4";
        sin = 1'b0;
        load_word(8'h55);
        sb = 1'b1; tick(5);
        chk(so, 1'b1, "R5");
        for (int k = 0; k < 3; k++) pulse_a();
        chk(so, 1'b1, "R4");
        sb = 1'b0; tick(4);
        sa = 1'b1; tick(5);
        chk(so, 1'b0, "R4");
        sb = 1'b1; tick(5);
        chk(so, 1'b0, "R5");
        sb = 1'b0; sa = 1'b0; tick(4);
        sb = 1'b1; tick(4); sb = 1'b0; tick(4);
        chk(so, 1'b1, "R4");

        // R6: edge during load is dropped, release with clock high
        cur_req = "R6";
        load_n = 1'b0; par = 8'h40; tick(1);
        sa = 1'b1; tick(5);
        load_n = 1'b1; tick(5);
        chk(so, 1'b0, "R6");
        sa = 1'b0; tick(4);
        pulse_a();
        chk(so, 1'b1, "R6");

        // R8: reset mid-operation
        cur_req = "R8";
        load_word(8'hFF);
        chk(so, 1'b1, "R8");
        rst_n = 1'b0; tick(1);
        chk(so, 1'b0, "R8"); chk(sno, 1'b1, "R8");
        rst_n = 1'b1; tick(2);
        live = 1'b0;
        finish_run();
    end
endmodule